// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a 52-bit physical address. It walks a four-level radix tree of translation tables held in memory, starting from a root table base supplied on an input. Every table holds 512 eight-byte entries, so a table occupies one 4KB page. The walker reads one entry per level through a simple read port with a request handshake and a separate response strobe.

A walk normally visits all four levels and yields a 4KB mapping. An entry at the second or third level can instead be marked as a large-page leaf, which ends the walk early with a 1GB or a 2MB mapping. An entry whose present bit is clear ends the walk with a translation fault. The walker serves one request at a time and reports each result with a one-cycle strobe, together with a page-size code.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` and `mem_req_valid` are 0.
- R2: The entry address at each level is the current table base with bits 11:0 replaced by {index, 3'b000}. The index is va[47:39] at the top level (whose base is `root_base`), then va[38:30], va[29:21] and va[20:12]. The base for the next level is entry bits 51:12 followed by twelve zero bits.
- R3: When no entry ends the walk early, the walk issues exactly four reads, top level first. It returns `resp_pa` = {leaf bits 51:12, va[11:0]}, `resp_size` = 0 (4KB) and `resp_fault` = 0.
- R4: A third-level entry with bit 0 and bit 7 set ends the walk after three reads. It returns `resp_pa` = {entry bits 51:21, va[20:0]} and `resp_size` = 1 (2MB). Entry bits 20:12 have no effect.
- R5: A second-level entry with bit 0 and bit 7 set ends the walk after two reads. It returns `resp_pa` = {entry bits 51:30, va[29:0]} and `resp_size` = 2 (1GB). Entry bits 29:12 have no effect.
- R6: An entry with bit 0 clear, at any level, ends the walk with no further read. It returns `resp_fault` = 1, `resp_pa` = 0 and `resp_size` = 0.
- R7: Bit 7 has no effect at the top level, where the entry is still followed as a table pointer, or at the fourth level, where the result is still a 4KB page.
- R8: `req_ready` is 1 only while the walker is idle. From the cycle after a request is accepted until the cycle after its response strobe, `req_ready` is 0 and no further request is taken. While idle, `mem_req_valid` is 0.
- R9: Once `mem_req_valid` is 1, it stays 1 and `mem_req_addr` stays unchanged until a cycle with `mem_req_ready` = 1.
- R10: Each accepted request produces exactly one response, signalled by `resp_valid` high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_base | input | 52 | Physical base of the top-level table (bits 11:0 ignored) |
| req_valid | input | 1 | Translation request present |
| req_va | input | 48 | Virtual address to translate |
| req_ready | output | 1 | Walker idle, request taken when req_valid is also 1 |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_fault | output | 1 | Walk stopped on a non-present entry |
| resp_size | output | 2 | 0 = 4KB, 1 = 2MB, 2 = 1GB |
| resp_pa | output | 52 | Translated physical address, 0 on a fault |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |

## Verification
A wrong level counter or a stale table base shows up at the read port on the very next handshake, as an entry address that differs from the one a behavioural walk over the same memory image predicts. A wrong leaf decision shows up as an extra or a missing read before the strobe, or as a response whose size code does not match the number of reads. A stuck state machine shows up within a cycle as `req_ready` disagreeing with the busy state the bench tracks, and a missing or doubled strobe is caught when the response pulse is counted. Junk in the frame bits below a large-page boundary and a large flag placed at the wrong levels are planted deliberately, so that mishandling either one changes `resp_pa` or the read sequence.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W     = 48;
    localparam int PA_W     = 52;
    localparam int PTE_W    = 64;
    localparam int OFF_W    = 12;
    localparam int IDX_W    = 9;
    localparam int LEVELS   = 4;

    // entry bit positions the decoder depends on
    localparam int PTE_PRESENT_BIT = 0;
    localparam int PTE_LARGE_BIT   = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        SZ_4K = 2'd0,
        SZ_2M = 2'd1,
        SZ_1G = 2'd2
    } page_size_e;

    function automatic logic pte_present(input logic [PTE_W-1:0] e);
        return e[PTE_PRESENT_BIT];
    endfunction

    function automatic logic pte_large(input logic [PTE_W-1:0] e);
        return e[PTE_LARGE_BIT];
    endfunction

endpackage

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
    parameter int VA_W   = ptw_pkg::VA_W,
    parameter int PA_W   = ptw_pkg::PA_W,
    parameter int OFF_W  = ptw_pkg::OFF_W,
    parameter int IDX_W  = ptw_pkg::IDX_W,
    parameter int LEVELS = ptw_pkg::LEVELS,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] level,
    input  logic [PA_W-1:0]  table_base,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int ENT_SH = OFF_W - IDX_W;

    logic [IDX_W-1:0] idx_by_lvl [LEVELS];
    logic [IDX_W-1:0] idx;

    // level 0 takes the highest index field, the last level the lowest
    for (genvar l = 0; l < LEVELS; l++) begin : g_idx
        localparam int LSB = OFF_W + IDX_W * (LEVELS - 1 - l);
        assign idx_by_lvl[l] = va[LSB +: IDX_W];
    end

    assign idx        = idx_by_lvl[level];
    assign entry_addr = {table_base[PA_W-1:OFF_W], idx, {ENT_SH{1'b0}}};

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
    parameter int VA_W   = ptw_pkg::VA_W,
    parameter int PA_W   = ptw_pkg::PA_W,
    parameter int PTE_W  = ptw_pkg::PTE_W,
    parameter int OFF_W  = ptw_pkg::OFF_W,
    parameter int IDX_W  = ptw_pkg::IDX_W,
    parameter int LEVELS = ptw_pkg::LEVELS,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [LVL_W-1:0] level,
    input  logic [VA_W-1:0]  va,
    output logic             present,
    output logic             is_leaf,
    output logic [PA_W-1:0]  next_base,
    output logic [PA_W-1:0]  leaf_pa,
    output logic [LVL_W-1:0] leaf_size
);
    import ptw_pkg::*;

    localparam logic [LVL_W-1:0] LAST = LVL_W'(LEVELS - 1);

    logic [PA_W-1:0] pa_by_lvl [LEVELS];
    logic            large_allowed;

    // candidate address for a walk ending at each level; the offset grows
    // by one index field for every level skipped
    for (genvar l = 0; l < LEVELS; l++) begin : g_leaf
        localparam int OW = OFF_W + IDX_W * (LEVELS - 1 - l);
        if (l == 0) begin : g_top
            assign pa_by_lvl[l] = '0;
        end else begin : g_lower
            assign pa_by_lvl[l] = {pte[PA_W-1:OW], va[OW-1:0]};
        end
    end

    always_comb begin
        large_allowed = (level != '0) && (level != LAST);
        present       = pte_present(pte);
        is_leaf       = present && ((level == LAST) || (pte_large(pte) && large_allowed));
        next_base     = {pte[PA_W-1:OFF_W], {OFF_W{1'b0}}};
        leaf_pa       = pa_by_lvl[level];
        leaf_size     = LAST - level;
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int VA_W   = ptw_pkg::VA_W,
    parameter int PA_W   = ptw_pkg::PA_W,
    parameter int PTE_W  = ptw_pkg::PTE_W,
    parameter int OFF_W  = ptw_pkg::OFF_W,
    parameter int IDX_W  = ptw_pkg::IDX_W,
    parameter int LEVELS = ptw_pkg::LEVELS,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PA_W-1:0]  root_base,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    output logic             req_ready,
    output logic             resp_valid,
    output logic             resp_fault,
    output logic [LVL_W-1:0] resp_size,
    output logic [PA_W-1:0]  resp_pa,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);
    import ptw_pkg::*;

    localparam int CNT_W = $clog2(LEVELS + 1);

    walk_state_e      state;
    logic [LVL_W-1:0] level;
    logic [VA_W-1:0]  va_q;
    logic [PA_W-1:0]  base_q;

    logic             d_present;
    logic             d_leaf;
    logic [PA_W-1:0]  d_next_base;
    logic [PA_W-1:0]  d_leaf_pa;
    logic [LVL_W-1:0] d_size;

    ptw_idx_sel #(
        .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LEVELS(LEVELS)
    ) u_idx (
        .va         (va_q),
        .level      (level),
        .table_base (base_q),
        .entry_addr (mem_req_addr)
    );

    ptw_pte_decode #(
        .VA_W(VA_W), .PA_W(PA_W), .PTE_W(PTE_W), .OFF_W(OFF_W),
        .IDX_W(IDX_W), .LEVELS(LEVELS)
    ) u_dec (
        .pte       (mem_rsp_data),
        .level     (level),
        .va        (va_q),
        .present   (d_present),
        .is_leaf   (d_leaf),
        .next_base (d_next_base),
        .leaf_pa   (d_leaf_pa),
        .leaf_size (d_size)
    );

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_ISSUE);
    assign resp_valid    = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            level      <= '0;
            va_q       <= '0;
            base_q     <= '0;
            resp_fault <= 1'b0;
            resp_size  <= '0;
            resp_pa    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_va;
                    base_q <= {root_base[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                    level  <= '0;
                    state  <= ST_ISSUE;
                end
                ST_ISSUE: if (mem_req_ready) begin
                    state <= ST_WAIT;
                end
                ST_WAIT: if (mem_rsp_valid) begin
                    if (!d_present) begin
                        resp_fault <= 1'b1;
                        resp_pa    <= '0;
                        resp_size  <= '0;
                        state      <= ST_DONE;
                    end else if (d_leaf) begin
                        resp_fault <= 1'b0;
                        resp_pa    <= d_leaf_pa;
                        resp_size  <= d_size;
                        state      <= ST_DONE;
                    end else begin
                        base_q <= d_next_base;
                        level  <= level + LVL_W'(1);
                        state  <= ST_ISSUE;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // reads issued in the current walk, kept only for the depth check below
    logic [CNT_W-1:0] rd_seen;
    always_ff @(posedge clk) begin
        if (rst || (req_valid && req_ready)) rd_seen <= '0;
        else if (mem_req_valid && mem_req_ready) rd_seen <= rd_seen + CNT_W'(1);
    end

    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req_valid && !resp_valid));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    p_fault_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (resp_pa == '0 && resp_size == '0));

    p_depth_r5: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_fault) |-> (rd_seen == CNT_W'(LEVELS) - CNT_W'(resp_size)));

endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;

    localparam logic [51:0] ROOT = 52'h0_0000_0010_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [51:0] root_base = ROOT;
    logic        req_valid = 1'b0;
    logic [47:0] req_va = '0;
    logic        req_ready;
    logic        resp_valid, resp_fault;
    logic [1:0]  resp_size;
    logic [51:0] resp_pa;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    ptw_walker u_ptw_walker (
        .clk(clk), .rst(rst), .root_base(root_base),
        .req_valid(req_valid), .req_va(req_va), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_size(resp_size), .resp_pa(resp_pa),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- memory image ----------------
    logic [63:0] mem [logic [51:0]];
    logic [51:0] next_page = 52'h0_0000_1000_0000;

    function automatic logic [63:0] mem_rd(input logic [51:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'h0;
    endfunction

    function automatic logic [51:0] eaddr(input logic [51:0] base, input logic [47:0] va, input int l);
        logic [8:0] ix;
        ix = 9'((va >> (39 - 9 * l)) & 48'h1FF);
        return {base[51:12], 12'h000} + {40'h0, ix, 3'b000};
    endfunction

    function automatic logic [51:0] alloc();
        logic [51:0] p;
        p = next_page;
        next_page = next_page + 52'h1000;
        return p;
    endfunction

    function automatic logic [63:0] ptr(input logic [51:0] t);
        return {12'h000, t[51:12], 12'h001};
    endfunction

    // ---------------- reference walk ----------------
    logic [51:0] exp_q[$];
    bit          exp_fault;
    logic [51:0] exp_pa;
    logic [1:0]  exp_sz;
    string       cur_tag = "R3";

    task automatic ref_walk(input logic [47:0] va);
        logic [51:0] base, a, mask;
        logic [63:0] e;
        int ob;
        bit done;
        base = ROOT;
        done = 0;
        exp_q.delete();
        exp_fault = 0; exp_pa = '0; exp_sz = '0;
        for (int l = 0; l < 4; l++) begin
            if (!done) begin
                a = eaddr(base, va, l);
                exp_q.push_back(a);
                e = mem_rd(a);
                if (!e[0]) begin
                    exp_fault = 1; done = 1;
                end else if (l == 3 || (e[7] && (l == 1 || l == 2))) begin
                    ob = 12 + 9 * (3 - l);
                    mask = (52'h1 << ob) - 52'h1;
                    exp_pa = ({e[51:12], 12'h000} & ~mask) | ({4'h0, va} & mask);
                    exp_sz = 2'(3 - l);
                    done = 1;
                end else begin
                    base = {e[51:12], 12'h000};
                end
            end
        end
    endtask

    // ---------------- memory responder ----------------
    bit          rsp_pend = 0;
    int          rsp_dly = 0;
    logic [51:0] rsp_addr;
    bit          started = 0;

    always @(posedge clk) begin
        #1;
        mem_rsp_valid = 1'b0;
        if (rsp_pend) begin
            if (rsp_dly == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_rd(rsp_addr);
                rsp_pend = 0;
            end else rsp_dly--;
        end
        mem_req_ready = ($urandom % 4) != 0;
    end

    // ---------------- per-cycle monitor ----------------
    bit          busy = 0;
    bit          hold_prev = 0;
    logic [51:0] prev_addr;
    bit          prev_resp = 0;
    int          resp_cnt = 0;

    always @(negedge clk) begin
        if (started) begin
            chk(req_ready == !busy, "R8 ready", 64'(req_ready), 64'(!busy));
            if (!busy) chk(!mem_req_valid, "R8 idle read", 64'(mem_req_valid), 64'h0);
            if (hold_prev)
                chk(mem_req_valid && mem_req_addr == prev_addr, "R9 hold",
                    64'(mem_req_addr), 64'(prev_addr));
            if (mem_req_valid && mem_req_ready) begin
                hold_prev = 0;
                if (exp_q.size() == 0) chk(0, "R2 extra read", 64'(mem_req_addr), 64'h0);
                else chk(mem_req_addr == exp_q[0], "R2 entry addr",
                         64'(mem_req_addr), 64'(exp_q[0]));
                if (exp_q.size() != 0) void'(exp_q.pop_front());
                rsp_pend = 1; rsp_addr = mem_req_addr; rsp_dly = $urandom % 3;
            end else begin
                hold_prev = mem_req_valid;
                prev_addr = mem_req_addr;
            end
            if (resp_valid) begin
                chk(!prev_resp, "R10 pulse", 64'(prev_resp), 64'h0);
                chk(busy, "R10 unrequested", 64'(busy), 64'h1);
                chk(resp_fault == exp_fault, {cur_tag, " fault"}, 64'(resp_fault), 64'(exp_fault));
                chk(resp_pa == exp_pa, {cur_tag, " pa"}, 64'(resp_pa), 64'(exp_pa));
                chk(resp_size == exp_sz, {cur_tag, " size"}, 64'(resp_size), 64'(exp_sz));
                chk(exp_q.size() == 0, {cur_tag, " read count"}, 64'(exp_q.size()), 64'h0);
                busy = 0;
                resp_cnt++;
            end
            prev_resp = resp_valid;
            if (req_valid && req_ready) begin
                ref_walk(req_va);
                busy = 1;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic walk(input logic [47:0] va, input string tag, input bit hold_req);
        int start_cnt;
        int guard;
        start_cnt = resp_cnt;
        cur_tag = tag;
        @(posedge clk); #1;
        req_valid = 1'b1; req_va = va;
        @(posedge clk); #1;
        if (hold_req) req_va = ~va;   // a second request kept pending while busy
        else req_valid = 1'b0;
        guard = 0;
        while (resp_cnt == start_cnt && guard < 300) begin
            @(negedge clk); guard++;
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk(resp_cnt == start_cnt + 1, {tag, " R10 one response"}, 64'(resp_cnt - start_cnt), 64'h1);
        @(negedge clk);
        chk(resp_cnt == start_cnt + 1, {tag, " R8 no second accept"}, 64'(busy), 64'h0);
    endtask

    task automatic map4k(input logic [47:0] va, input logic [51:0] frame, input logic [63:0] extra);
        logic [51:0] t1, t2, t3;
        t1 = alloc(); t2 = alloc(); t3 = alloc();
        mem[eaddr(ROOT, va, 0)] = ptr(t1);
        mem[eaddr(t1, va, 1)]   = ptr(t2);
        mem[eaddr(t2, va, 2)]   = ptr(t3);
        mem[eaddr(t3, va, 3)]   = {12'h000, frame[51:12], 12'h003} | extra;
    endtask

    task automatic map2m(input logic [47:0] va, input logic [51:0] frame);
        logic [51:0] t1, t2;
        t1 = alloc(); t2 = alloc();
        mem[eaddr(ROOT, va, 0)] = ptr(t1);
        mem[eaddr(t1, va, 1)]   = ptr(t2);
        mem[eaddr(t2, va, 2)]   = {12'h000, frame[51:12], 12'h083};
    endtask

    task automatic map1g(input logic [47:0] va, input logic [51:0] frame);
        logic [51:0] t1;
        t1 = alloc();
        mem[eaddr(ROOT, va, 0)] = ptr(t1);
        mem[eaddr(t1, va, 1)]   = {12'h000, frame[51:12], 12'h081};
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired t=%0t", $time);
        finish_run();
    end

    initial begin
        logic [47:0] va;
        logic [51:0] t1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'h1);
        chk(resp_valid == 1'b0, "R1 resp_valid", 64'(resp_valid), 64'h0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'h0);
        started = 1;

        // R3 / R2: full four-level walk
        va = 48'h1234_5678_9ABC;
        map4k(va, 52'hA_BCDE_F012_3000, 64'h0);
        walk(va, "R3 4k", 0);
        chk(resp_pa == 52'hA_BCDE_F012_3ABC, "R3 pa direct", 64'(resp_pa), 64'hA_BCDE_F012_3ABC);

        // R4: 2MB leaf, junk in frame bits 20:12
        va = 48'h2345_6789_ABCD;
        map2m(va, 52'h5_5555_555F_F000);
        walk(va, "R4 2m", 0);
        chk(resp_pa == {31'h2AAA_AAAA, va[20:0]}, "R4 pa direct", 64'(resp_pa),
            64'({31'h2AAA_AAAA, va[20:0]}));

        // R5: 1GB leaf, junk in frame bits 29:12
        va = 48'h3456_789A_BCDE;
        map1g(va, 52'h7_7777_7FFF_F000);
        walk(va, "R5 1g", 0);
        chk(resp_size == 2'd2, "R5 size direct", 64'(resp_size), 64'h2);

        // R6: fault at the top level and at the third level
        walk(48'h7FFF_0000_0000, "R6 fault top", 0);
        va = 48'h4567_0000_1000;
        t1 = alloc();
        mem[eaddr(ROOT, va, 0)] = ptr(t1);
        mem[eaddr(t1, va, 1)]   = ptr(alloc());
        walk(va, "R6 fault lvl3", 0);

        // R7: large flag at the top level is followed as a pointer
        va = 48'h5678_1234_5678;
        map4k(va, 52'h1_2345_6789_A000, 64'h0);
        mem[eaddr(ROOT, va, 0)] = mem[eaddr(ROOT, va, 0)] | 64'h80;
        walk(va, "R7 top large", 0);
        // R7: large flag at the leaf still gives a 4KB page
        va = 48'h6789_0FED_CBA9;
        map4k(va, 52'h2_4680_ACE1_3000, 64'h80);
        walk(va, "R7 leaf large", 0);

        // R8: request held high while the walker is busy
        va = 48'h1234_5678_9ABC;
        walk(va, "R8 held req", 1);

        // mixed random walks (R2..R6)
        for (int i = 0; i < 40; i++) begin
            logic [47:0] rva;
            logic [51:0] fr;
            int kind;
            rva  = 48'({$urandom, $urandom});
            fr   = 52'({$urandom, $urandom}) & 52'hF_FFFF_FFFF_F000;
            kind = $urandom % 4;
            case (kind)
                0: map4k(rva, fr, 64'h0);
                1: map2m(rva, fr);
                2: map1g(rva, fr);
                default: ;
            endcase
            walk(rva, kind == 0 ? "R3 rnd" : kind == 1 ? "R4 rnd" : kind == 2 ? "R5 rnd" : "R6 rnd", (i % 5) == 0);
        end

        repeat (5) @(posedge clk);
        finish_run();
    end

endmodule